// File: doc/BRIEF.md
# Trimmable Seconds Clock with Alarm

This block turns a slow reference pulse stream (nominally 32.768 kHz, presented as one-cycle enables in the system clock domain) into a nominal 1 Hz tick and counts those ticks in a 32-bit seconds register. The tick period is set by a programmable divider limit. A trim correction stretches the long-term period: after every 1024 ticks, a programmable number of reference pulses is swallowed before the divider resumes. Software can adjust the trim to cancel a crystal's frequency error.

A 32-bit alarm value is compared with the seconds count whenever the count advances. A four-bit status word holds two sticky event flags, one for the alarm and one for the tick, and an interrupt enable for each. The interrupt output is asserted while any enabled flag is set. Registers are reached through a plain write port and a combinational read port.

Top module: `rtc_trim_top`

## Requirements
- R1: The trim register holds the divider limit C in bits 15:0. With no pulse deletion pending, a tick occurs on every (C+1)th reference pulse. Cycles with `ref_pulse` low do not advance the divider.
- R2: The trim register holds the delete count D in bits 25:16. The divider restarts on a trim write. On the tick that completes each group of 1024 ticks counted from that restart, the following D reference pulses are discarded. One group therefore spans 1024*(C+1)+D pulses.
- R3: Every tick increments the 32-bit seconds count by one, wrapping from 0xFFFFFFFF to 0.
- R4: Register select codes are 0 alarm, 1 seconds count, 2 trim and 3 status. A write takes effect at the next clock edge. `rd_data` shows the selected register combinationally. Unused trim and status bits read as 0.
- R5: A write to the seconds count in the same cycle as a tick loads the written value, and that tick adds nothing.
- R6: Status bit 0 (alarm flag) is set when a tick-driven increment produces a count equal to the alarm value. Loading the count with the alarm value by a write does not set it.
- R7: Status bit 1 (tick flag) is set on every tick.
- R8: A status write clears bit 0 and/or bit 1 where the written bit is 1, and loads bits 2 (alarm enable) and 3 (tick enable) from the data. A flag event in the same cycle as its clear leaves the flag set.
- R9: `irq` equals (bit 0 AND bit 2) OR (bit 1 AND bit 3) of the status word.
- R10: A trim write clears the divider, the tick group counter and any pending deletion. A reference pulse in the cycle of that write produces no tick.
- R11: After reset, alarm, count and status are 0, C is 32767 and D is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle enable per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in one cycle. A tick can coincide with a software write to the seconds count, and a flag event can coincide with a write-1 clear of the same flag. The bench provokes both by counting reference pulses so that the write is issued together with the pulse that completes the divider. It judges the result by reading the count and status on the following cycle against a behavioural model that runs alongside the design on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        SEL_ALARM  = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_TRIM   = 2'd2,
        SEL_STATUS = 2'd3
    } rtc_sel_e;

    localparam int ST_ALARM_FLAG = 0;
    localparam int ST_TICK_FLAG  = 1;
    localparam int ST_ALARM_EN   = 2;
    localparam int ST_TICK_EN    = 3;
    localparam int ST_W          = 4;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W  = 16,
    parameter int DEL_W  = 10,
    parameter int GRP_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_lim,
    input  logic [DEL_W-1:0] del_cnt,
    output logic             tick
);

    localparam logic [DIV_W-1:0] DIV_ONE  = {{(DIV_W-1){1'b0}}, 1'b1};
    localparam logic [DEL_W-1:0] DEL_ONE  = {{(DEL_W-1){1'b0}}, 1'b1};
    localparam logic [GRP_W-1:0] GRP_ONE  = {{(GRP_W-1){1'b0}}, 1'b1};
    localparam logic [GRP_W-1:0] GRP_LAST = '1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [GRP_W-1:0] grp;
        logic [DEL_W-1:0] skip;
    } pre_t;

    pre_t st_d, st_q;
    logic tick_c;

    always_comb begin
        st_d   = st_q;
        tick_c = 1'b0;
        if (restart) begin
            st_d = '0;
        end else if (ref_pulse) begin
            if (st_q.skip != '0) begin
                st_d.skip = st_q.skip - DEL_ONE;
            end else if (st_q.div >= div_lim) begin
                tick_c    = 1'b1;
                st_d.div  = '0;
                st_d.grp  = st_q.grp + GRP_ONE;
                if (st_q.grp == GRP_LAST) begin
                    st_d.skip = del_cnt;
                end
            end else begin
                st_d.div = st_q.div + DIV_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = tick_c;

    // R1: the divider never runs past its limit
    a_r1_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.div <= div_lim);

    // R2: no tick while reference pulses are being discarded
    a_r2_quiet_while_skipping: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.skip != '0) |-> !tick);

    // R10: a restart leaves the whole prescaler state at zero
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.div == '0 && st_q.grp == '0 && st_q.skip == '0));

    // R1: after a tick the divider starts over
    a_r1_tick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> st_q.div == '0);

endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             alm_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] alarm,
    output logic             match
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] alm;
    } sec_t;

    sec_t st_d, st_q;
    logic [CNT_W-1:0] inc_c;
    logic             match_c;

    always_comb begin
        st_d    = st_q;
        inc_c   = st_q.cnt + CNT_ONE;
        match_c = 1'b0;
        if (cnt_we) begin
            st_d.cnt = wdata;
        end else if (tick) begin
            st_d.cnt = inc_c;
            match_c  = (inc_c == st_q.alm);
        end
        if (alm_we) begin
            st_d.alm = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign alarm = st_q.alm;
    assign match = match_c;

    // R3: an undisturbed tick adds exactly one
    a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we) |=> count == $past(count) + CNT_ONE);

    // R5: a count write always wins over a coincident tick
    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count == $past(wdata));

    // R6: a match event leaves count equal to the alarm value
    a_r6_match_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !alm_we) |=> count == alarm);

endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alarm_evt,
    input  logic            tick_evt,
    input  logic            st_we,
    input  logic [ST_W-1:0] st_wdata,
    output logic [ST_W-1:0] status,
    output logic            irq
);

    typedef struct packed {
        logic al_flag;
        logic hz_flag;
        logic al_en;
        logic hz_en;
    } st_t;

    st_t st_d, st_q;
    logic clr_al, clr_hz;

    always_comb begin
        st_d    = st_q;
        clr_al  = st_we && st_wdata[ST_ALARM_FLAG];
        clr_hz  = st_we && st_wdata[ST_TICK_FLAG];
        st_d.al_flag = alarm_evt || (st_q.al_flag && !clr_al);
        st_d.hz_flag = tick_evt  || (st_q.hz_flag && !clr_hz);
        if (st_we) begin
            st_d.al_en = st_wdata[ST_ALARM_EN];
            st_d.hz_en = st_wdata[ST_TICK_EN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status = '0;
        status[ST_ALARM_FLAG] = st_q.al_flag;
        status[ST_TICK_FLAG]  = st_q.hz_flag;
        status[ST_ALARM_EN]   = st_q.al_en;
        status[ST_TICK_EN]    = st_q.hz_en;
        irq = (st_q.al_flag && st_q.al_en) || (st_q.hz_flag && st_q.hz_en);
    end

    // R8: an alarm event is never lost to a coincident clear
    a_r8_alarm_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> status[ST_ALARM_FLAG]);

    // R7: every tick raises the tick flag
    a_r7_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> status[ST_TICK_FLAG]);

    // R8: a write-1 clear with no new event drops the alarm flag
    a_r8_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && st_wdata[ST_ALARM_FLAG] && !alarm_evt) |=> !status[ST_ALARM_FLAG]);

endmodule

// File: rtl/rtc_trim_top.sv
module rtc_trim_top
    import rtc_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int DIV_W     = 16,
    parameter int DEL_W     = 10,
    parameter int GRP_W     = 10,
    parameter int DIV_RESET = 32767
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    localparam int DEL_LSB = DIV_W;
    localparam logic [DIV_W-1:0] DIV_RST_V = DIV_W'(DIV_RESET);

    typedef struct packed {
        logic [DIV_W-1:0] lim;
        logic [DEL_W-1:0] del;
    } trim_t;

    trim_t trim_d, trim_q;
    rtc_sel_e wsel, rsel;
    logic we_alarm, we_count, we_trim, we_status;
    logic tick, match;
    logic [CNT_W-1:0] count, alarm;
    logic [ST_W-1:0] status;

    always_comb begin
        wsel      = rtc_sel_e'(wr_sel);
        we_alarm  = wr_en && (wsel == SEL_ALARM);
        we_count  = wr_en && (wsel == SEL_COUNT);
        we_trim   = wr_en && (wsel == SEL_TRIM);
        we_status = wr_en && (wsel == SEL_STATUS);
        trim_d    = trim_q;
        if (we_trim) begin
            trim_d.lim = wr_data[DIV_W-1:0];
            trim_d.del = wr_data[DEL_LSB +: DEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_q.lim <= DIV_RST_V;
            trim_q.del <= '0;
        end else begin
            trim_q <= trim_d;
        end
    end

    rtc_prescaler #(
        .DIV_W (DIV_W),
        .DEL_W (DEL_W),
        .GRP_W (GRP_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .restart   (we_trim),
        .div_lim   (trim_q.lim),
        .del_cnt   (trim_q.del),
        .tick      (tick)
    );

    rtc_seconds #(
        .CNT_W (CNT_W)
    ) u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cnt_we (we_count),
        .alm_we (we_alarm),
        .wdata  (wr_data),
        .count  (count),
        .alarm  (alarm),
        .match  (match)
    );

    rtc_status u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_evt (match),
        .tick_evt  (tick),
        .st_we     (we_status),
        .st_wdata  (wr_data[ST_W-1:0]),
        .status    (status),
        .irq       (irq)
    );

    always_comb begin
        rsel    = rtc_sel_e'(rd_sel);
        rd_data = '0;
        case (rsel)
            SEL_ALARM:  rd_data = alarm;
            SEL_COUNT:  rd_data = count;
            SEL_TRIM: begin
                rd_data[DIV_W-1:0]       = trim_q.lim;
                rd_data[DEL_LSB +: DEL_W] = trim_q.del;
            end
            default:    rd_data[ST_W-1:0] = status;
        endcase
    end

    // R4: the trim register only changes on a trim write
    a_r4_trim_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we_trim |=> $stable(trim_q));

    // R9: interrupt never raised with all flags clear
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[ST_ALARM_FLAG] || status[ST_TICK_FLAG]));

endmodule

// File: tb/test_rtc_trim_top.sv
`timescale 1ns/1ps
module test_rtc_trim_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_pulse = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [31:0] m_alarm, m_count;
    int          m_c, m_d, m_div, m_ticks, m_del;
    bit          m_al, m_hz, m_ae, m_he;
    logic [31:0] rv [4];

    always #2.5 clk = ~clk;

    rtc_trim_top i_rtc_trim_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic model_init();
        m_alarm = 0; m_count = 0; m_c = 32767; m_d = 0;
        m_div = 0; m_ticks = 0; m_del = 0;
        m_al = 0; m_hz = 0; m_ae = 0; m_he = 0;
    endtask

    task automatic model_step(input bit rp, input bit we, input logic [1:0] s, input logic [31:0] d);
        bit tk = 0;
        bit hit = 0;
        if (we && s == 2'd2) begin
            m_div = 0; m_ticks = 0; m_del = 0;
        end else if (rp) begin
            if (m_del > 0) m_del--;
            else if (m_div == m_c) begin
                tk = 1; m_div = 0; m_ticks++;
                if (m_ticks % 1024 == 0) m_del = m_d;
            end else m_div++;
        end
        if (we && s == 2'd1) m_count = d;
        else if (tk) begin
            hit = (m_count + 32'd1 == m_alarm);
            m_count = m_count + 32'd1;
        end
        m_al = hit || (m_al && !(we && s == 2'd3 && d[0]));
        m_hz = tk  || (m_hz && !(we && s == 2'd3 && d[1]));
        if (we && s == 2'd3) begin m_ae = d[2]; m_he = d[3]; end
        if (we && s == 2'd0) m_alarm = d;
        if (we && s == 2'd2) begin m_c = int'(d[15:0]); m_d = int'(d[25:16]); end
    endtask

    task automatic compare();
        for (int s = 0; s < 4; s++) begin
            rd_sel = s[1:0];
            #0.4;
            rv[s] = rd_data;
        end
        chk("R4 alarm", rv[0], m_alarm);
        chk("R3 count", rv[1], m_count);
        chk("R4 trim", rv[2], {6'd0, m_d[9:0], m_c[15:0]});
        chk("R8 status", rv[3], {28'd0, m_he, m_ae, m_hz, m_al});
        chk("R9 irq", {31'd0, irq}, {31'd0, (m_al && m_ae) || (m_hz && m_he)});
    endtask

    task automatic cycle(input bit rp, input bit we, input logic [1:0] s, input logic [31:0] d);
        ref_pulse = rp; wr_en = we; wr_sel = s; wr_data = d;
        @(posedge clk);
        model_step(rp, we, s, d);
        @(negedge clk);
        compare();
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            cycle(1'b1, 1'b0, 2'd0, 32'd0);
            cycle(1'b0, 1'b0, 2'd0, 32'd0);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        cycle(1'b0, 1'b1, s, d);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all R): got timeout exp completion");
        finish_run();
    end

    initial begin
        model_init();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare();
        // R11 reset values
        chk("R11 trim reset", rv[2], 32'h0000_7FFF);
        chk("R11 count reset", rv[1], 32'd0);
        chk("R11 status reset", rv[3], 32'd0);

        // R1 plain division, C=3
        wr(2'd2, 32'h0000_0003);
        pulse(8);
        chk("R1 two ticks after 8 pulses", rv[1], 32'd2);
        repeat (5) cycle(1'b0, 1'b0, 2'd0, 32'd0);
        chk("R1 idle cycles ignored", rv[1], 32'd2);
        chk("R7 tick flag", {31'd0, rv[3][1]}, 32'd1);

        // R8 clear and enables, R9 irq
        wr(2'd3, 32'h3);
        chk("R8 flags cleared", rv[3], 32'd0);
        wr(2'd3, 32'hC);
        chk("R8 enables loaded", rv[3], 32'hC);
        chk("R9 irq low", {31'd0, irq}, 32'd0);
        pulse(4);
        chk("R9 irq from tick", {31'd0, irq}, 32'd1);

        // R8 clear coincident with tick
        pulse(3);
        cycle(1'b1, 1'b1, 2'd3, 32'hE);
        chk("R8 set beats clear", {31'd0, rv[3][1]}, 32'd1);

        // R6 alarm match only on increment
        wr(2'd3, 32'hF);
        wr(2'd0, 32'd10);
        wr(2'd1, 32'd10);
        chk("R6 no flag on write", {31'd0, rv[3][0]}, 32'd0);
        wr(2'd1, 32'd9);
        pulse(4);
        chk("R6 flag on increment", {31'd0, rv[3][0]}, 32'd1);
        chk("R9 irq from alarm", {31'd0, irq}, 32'd1);

        // R5 write wins over tick
        pulse(3);
        cycle(1'b1, 1'b1, 2'd1, 32'd100);
        chk("R5 write wins", rv[1], 32'd100);

        // R3 wrap
        wr(2'd1, 32'hFFFF_FFFF);
        pulse(4);
        chk("R3 wrap to zero", rv[1], 32'd0);

        // R10 trim write restarts divider
        pulse(2);
        wr(2'd2, 32'h0000_0003);
        pulse(3);
        chk("R10 no early tick", rv[1], 32'd0);
        pulse(1);
        chk("R10 tick after full period", rv[1], 32'd1);
        cycle(1'b1, 1'b1, 2'd2, 32'h0000_0003);
        chk("R10 no tick on trim write", rv[1], 32'd1);

        // R2 deletion after 1024 ticks, C=1 D=5
        wr(2'd2, 32'h0005_0001);
        chk("R4 trim readback", rv[2], 32'h0005_0001);
        chk("R4 alarm readback", rv[0], 32'd10);
        wr(2'd1, 32'd0);
        pulse(2048);
        chk("R2 group complete", rv[1], 32'd1024);
        pulse(5);
        chk("R2 pulses deleted", rv[1], 32'd1024);
        pulse(1);
        chk("R2 divider resumed", rv[1], 32'd1024);
        pulse(1);
        chk("R2 first tick after deletion", rv[1], 32'd1025);

        finish_run();
    end

endmodule